// File: doc/BRIEF.md
# Video Crosspoint Configuration Register Bank

This block holds the configuration state of a crosspoint that can connect any of sixteen sources to any of sixteen destinations. It accepts 16-bit command words on a valid/ready port and keeps the following state:

- a 4-bit source index per destination;
- a drive-enable bit per destination;
- a gain bit per destination;
- a global power bit;
- a shared enable bit;
- a broadcast flag, with its own source index.

For every destination it presents three things combinationally from that state: the source index currently in force, the enable actually applied, and the gain bit.

The command port never applies back-pressure. `cmd_ready` is held high, and a word is taken on every rising clock edge at which `cmd_valid` is high, including back-to-back cycles. An accepted word updates state at that edge, and the outputs show the new value in the following cycle. A malformed word changes nothing and raises `cmd_illegal` for exactly the cycle after its acceptance edge.

Broadcast mode overrides the per-destination table without erasing it. The table can still be written while broadcast is active, and it takes effect again the moment the flag is cleared.

Top module: `xpt_cfg_bank`

## Requirements
- R1: While `rst_n` is low and after its release, all of these are zero: every output enable, gain bit, source index and the illegal flag. The power bit, shared enable, broadcast flag and broadcast source are also cleared.
- R2: The command is chosen by word bits 15:13. 3'b111 is the control word: bit 1 sets power and bit 0 sets the shared enable.
- R3: Opcode 3'b001 writes per-destination enables for the group of four destinations starting at 4*G, where G is bits 9:8. Bits 0, 2, 4 and 6 go to destinations 4G, 4G+1, 4G+2 and 4G+3. Destinations outside the group keep their bits.
- R4: Opcode 3'b010 writes gain bits with the same group layout as R3. On `out_gain`, a 1 means gain of two and a 0 means gain of one.
- R5: Opcode 3'b000 stores the source in bits 12:9 as the table entry of the destination in bits 4:1. Destination d shows it on `out_sel[4d+3:4d]`.
- R6: Opcode 3'b011 loads the broadcast flag from bit 0 and the broadcast source from bits 12:9. While the flag is set, every destination shows the broadcast source.
- R7: The table keeps its contents while broadcast is on, and accepts route writes during that time. Clearing the flag makes every table entry visible again at once.
- R8: `out_enable[d]` is high only when destination d's own enable, the shared enable and the power bit are all set.
- R9: A word is illegal, changes no state, and makes `cmd_illegal` high for one cycle if any of these holds:
  - its opcode is 3'b100, 3'b101 or 3'b110;
  - it is a control word with any of bits 8:2 set;
  - it is a route word with bit 8 or bit 0 set;
  - it is a broadcast word with bit 8 set.
- R10: `cmd_ready` is always high, and words presented on consecutive cycles are each applied in order.
- R11: A word present while `cmd_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command accepted (constant high) |
| cmd_word | input | 16 | Command word |
| out_sel | output | 64 | Source index in force, 4 bits per destination |
| out_enable | output | 16 | Effective drive enable per destination |
| out_gain | output | 16 | Gain bit per destination (1 = x2) |
| cmd_illegal | output | 1 | One-cycle pulse after a rejected word |

## Verification
The bench builds the block with its default sixteen destinations, so there are four enable/gain groups. That makes the first and last groups reachable, along with route writes to destination 0 and destination 15. All four nibbles of the source field are exercised, including the all-ones source.

The same build allows a route write to land while broadcast is active and then surface when the flag is cleared. It also lets the shared enable and the power bit each be toggled separately, to show the three-way AND behind every enable.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 4;
  localparam int GRP_SZ = 4;

  localparam logic [2:0] OP_ROUTE = 3'b000;
  localparam logic [2:0] OP_ENA   = 3'b001;
  localparam logic [2:0] OP_GAIN  = 3'b010;
  localparam logic [2:0] OP_BCAST = 3'b011;
  localparam logic [2:0] OP_CTRL  = 3'b111;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_ena;
    logic wr_gain;
    logic wr_route;
    logic wr_bcast;
    logic bad;
  } xpt_dec_t;
endpackage

// File: rtl/xpt_cmd_decode.sv
module xpt_cmd_decode
  import xpt_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output xpt_dec_t          dec
);
  always_comb begin
    dec = '0;
    if (cmd_valid) begin
      case (cmd_word[15:13])
        OP_CTRL:  if (|cmd_word[8:2]) dec.bad = 1'b1;
                  else                dec.wr_ctrl = 1'b1;
        OP_ENA:   dec.wr_ena = 1'b1;
        OP_GAIN:  dec.wr_gain = 1'b1;
        OP_ROUTE: if (cmd_word[8] | cmd_word[0]) dec.bad = 1'b1;
                  else                           dec.wr_route = 1'b1;
        OP_BCAST: if (cmd_word[8]) dec.bad = 1'b1;
                  else             dec.wr_bcast = 1'b1;
        default:  dec.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/xpt_state.sv
module xpt_state
  import xpt_pkg::*;
#(
  parameter int N_OUT = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  xpt_dec_t                    dec,
  input  logic [WORD_W-1:0]           cmd_word,
  output logic [N_OUT-1:0][SEL_W-1:0] route_q,
  output logic [N_OUT-1:0]            ena_q,
  output logic [N_OUT-1:0]            gain_q,
  output logic                        pwr_q,
  output logic                        com_q,
  output logic                        bc_on_q,
  output logic [SEL_W-1:0]            bc_sel_q,
  output logic                        illegal_q
);
  localparam int GRP_W = 2;

  logic [GRP_W-1:0] grp;
  logic [SEL_W-1:0] src_fld;
  logic [SEL_W-1:0] dst_fld;

  assign grp     = cmd_word[9:8];
  assign src_fld = cmd_word[12:9];
  assign dst_fld = cmd_word[4:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q     <= 1'b0;
      com_q     <= 1'b0;
      bc_on_q   <= 1'b0;
      bc_sel_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= dec.bad;
      if (dec.wr_ctrl) begin
        pwr_q <= cmd_word[1];
        com_q <= cmd_word[0];
      end
      if (dec.wr_bcast) begin
        bc_on_q  <= cmd_word[0];
        bc_sel_q <= src_fld;
      end
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_dst
    localparam logic [GRP_W-1:0] MY_GRP = GRP_W'(i / GRP_SZ);
    localparam int               MY_BIT = 2 * (i % GRP_SZ);
    localparam logic [SEL_W-1:0] MY_IDX = SEL_W'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ena_q[i]   <= 1'b0;
        gain_q[i]  <= 1'b0;
        route_q[i] <= '0;
      end else begin
        if (dec.wr_ena && grp == MY_GRP)    ena_q[i]   <= cmd_word[MY_BIT];
        if (dec.wr_gain && grp == MY_GRP)   gain_q[i]  <= cmd_word[MY_BIT];
        if (dec.wr_route && dst_fld == MY_IDX) route_q[i] <= src_fld;
      end
    end

    // R5: a route write lands in the addressed entry
    p_route_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.wr_route && dst_fld == MY_IDX) |=> route_q[i] == $past(src_fld));
  end

  // R9: a rejected word leaves all state untouched and pulses the flag
  p_bad_no_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec.bad |=> ($stable(route_q) && $stable(ena_q) && $stable(gain_q) &&
                 $stable(pwr_q) && $stable(com_q) && $stable(bc_on_q) &&
                 $stable(bc_sel_q) && illegal_q));

  // R11: no valid, no change
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(route_q) && $stable(ena_q) && $stable(gain_q) &&
                    $stable(pwr_q) && $stable(com_q) && $stable(bc_on_q) &&
                    !illegal_q));
endmodule

// File: rtl/xpt_out_resolve.sv
module xpt_out_resolve
  import xpt_pkg::*;
#(
  parameter int N_OUT = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_OUT-1:0][SEL_W-1:0] route_q,
  input  logic [N_OUT-1:0]            ena_q,
  input  logic [N_OUT-1:0]            gain_q,
  input  logic                        pwr_q,
  input  logic                        com_q,
  input  logic                        bc_on_q,
  input  logic [SEL_W-1:0]            bc_sel_q,
  output logic [N_OUT*SEL_W-1:0]      out_sel,
  output logic [N_OUT-1:0]            out_enable,
  output logic [N_OUT-1:0]            out_gain
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign out_sel[i*SEL_W +: SEL_W] = bc_on_q ? bc_sel_q : route_q[i];
    assign out_enable[i]             = ena_q[i] & com_q & pwr_q;
    assign out_gain[i]               = gain_q[i];

    // R6: broadcast forces every destination to the broadcast source
    p_bcast_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bc_on_q |-> out_sel[i*SEL_W +: SEL_W] == bc_sel_q);
    // R7: with broadcast off the stored table entry is in force
    p_table_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bc_on_q |-> out_sel[i*SEL_W +: SEL_W] == route_q[i]);
  end

  // R8: no destination drives unless power and shared enable are both set
  p_en_needs_pwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_enable) |-> (pwr_q && com_q));
endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank
  import xpt_pkg::*;
#(
  parameter int N_OUT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [WORD_W-1:0]      cmd_word,
  output logic [N_OUT*SEL_W-1:0] out_sel,
  output logic [N_OUT-1:0]       out_enable,
  output logic [N_OUT-1:0]       out_gain,
  output logic                   cmd_illegal
);
  xpt_dec_t                    dec;
  logic [N_OUT-1:0][SEL_W-1:0] route_q;
  logic [N_OUT-1:0]            ena_q;
  logic [N_OUT-1:0]            gain_q;
  logic                        pwr_q;
  logic                        com_q;
  logic                        bc_on_q;
  logic [SEL_W-1:0]            bc_sel_q;

  assign cmd_ready = 1'b1;

  xpt_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .dec       (dec)
  );

  xpt_state #(.N_OUT(N_OUT)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .dec       (dec),
    .cmd_word  (cmd_word),
    .route_q   (route_q),
    .ena_q     (ena_q),
    .gain_q    (gain_q),
    .pwr_q     (pwr_q),
    .com_q     (com_q),
    .bc_on_q   (bc_on_q),
    .bc_sel_q  (bc_sel_q),
    .illegal_q (cmd_illegal)
  );

  xpt_out_resolve #(.N_OUT(N_OUT)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .route_q    (route_q),
    .ena_q      (ena_q),
    .gain_q     (gain_q),
    .pwr_q      (pwr_q),
    .com_q      (com_q),
    .bc_on_q    (bc_on_q),
    .bc_sel_q   (bc_sel_q),
    .out_sel    (out_sel),
    .out_enable (out_enable),
    .out_gain   (out_gain)
  );

  // R10: the port never stalls
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> cmd_ready);
  // R1: the pulse never outlives a reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cmd_illegal);
endmodule

// File: tb/xpt_cfg_bank_bench.sv
module xpt_cfg_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic [63:0] out_sel;
  logic [15:0] out_enable;
  logic [15:0] out_gain;
  logic        cmd_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xpt_cfg_bank u_xpt_cfg_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .out_sel(out_sel), .out_enable(out_enable),
    .out_gain(out_gain), .cmd_illegal(cmd_illegal)
  );

  // {req[116:113], word[112:97], sel[96:33], en[32:17], gain[16:1], ill[0]}
  localparam int NV = 17;
  localparam logic [116:0] VEC [NV] = '{
    {4'd2,  16'hE003, 64'h0,                   16'h0000, 16'h0000, 1'b0}, // R2 power+shared
    {4'd3,  16'h2055, 64'h0,                   16'h000F, 16'h0000, 1'b0}, // R3 group 0
    {4'd3,  16'h2311, 64'h0,                   16'h500F, 16'h0000, 1'b0}, // R3 group 3
    {4'd4,  16'h4144, 64'h0,                   16'h500F, 16'h00A0, 1'b0}, // R4 gains 5,7
    {4'd5,  16'h1206, 64'h0000_0000_0000_9000, 16'h500F, 16'h00A0, 1'b0}, // R5 9->3
    {4'd5,  16'h1E1E, 64'hF000_0000_0000_9000, 16'h500F, 16'h00A0, 1'b0}, // R5 15->15
    {4'd6,  16'h6C01, 64'h6666_6666_6666_6666, 16'h500F, 16'h00A0, 1'b0}, // R6 bcast 6
    {4'd7,  16'h0400, 64'h6666_6666_6666_6666, 16'h500F, 16'h00A0, 1'b0}, // R7 hidden write
    {4'd7,  16'h6000, 64'hF000_0000_0000_9002, 16'h500F, 16'h00A0, 1'b0}, // R7 restore
    {4'd9,  16'h8FFF, 64'hF000_0000_0000_9002, 16'h500F, 16'h00A0, 1'b1}, // R9 opcode
    {4'd9,  16'h0201, 64'hF000_0000_0000_9002, 16'h500F, 16'h00A0, 1'b1}, // R9 route bit0
    {4'd9,  16'hE007, 64'hF000_0000_0000_9002, 16'h500F, 16'h00A0, 1'b1}, // R9 ctrl bit2
    {4'd8,  16'hE002, 64'hF000_0000_0000_9002, 16'h0000, 16'h00A0, 1'b0}, // R8 shared off
    {4'd8,  16'hE003, 64'hF000_0000_0000_9002, 16'h500F, 16'h00A0, 1'b0}, // R8 back on
    {4'd8,  16'hE001, 64'hF000_0000_0000_9002, 16'h0000, 16'h00A0, 1'b0}, // R8 power off
    {4'd2,  16'hE003, 64'hF000_0000_0000_9002, 16'h500F, 16'h00A0, 1'b0}, // R2 restore
    {4'd9,  16'h6D01, 64'hF000_0000_0000_9002, 16'h500F, 16'h00A0, 1'b1}  // R9 bcast bit8
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [63:0] s,
                           input logic [15:0] e, input logic [15:0] g, input logic il);
    check(req, "out_sel", out_sel, s);
    check(req, "out_enable", {48'h0, out_enable}, {48'h0, e});
    check(req, "out_gain", {48'h0, out_gain}, {48'h0, g});
    check(req, "cmd_illegal", {63'h0, cmd_illegal}, {63'h0, il});
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1", 64'h0, 16'h0, 16'h0, 1'b0);          // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", 64'h0, 16'h0, 16'h0, 1'b0);          // R1 after release
    check("R10", "cmd_ready", {63'h0, cmd_ready}, 64'h1);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k][112:97]);
      check_all($sformatf("R%0d", VEC[k][116:113]), VEC[k][96:33],
                VEC[k][32:17], VEC[k][16:1], VEC[k][0]);
    end

    // R9: pulse lasts one cycle only
    @(negedge clk);
    check("R9", "cmd_illegal drop", {63'h0, cmd_illegal}, 64'h0);

    // R11: word present without valid does nothing
    cmd_word = 16'h1E00;
    repeat (3) @(negedge clk);
    check("R11", "out_sel idle", out_sel, 64'hF000_0000_0000_9002);
    cmd_word = 16'hE000;
    @(negedge clk);
    check("R11", "out_enable idle", {48'h0, out_enable}, {48'h0, 16'h500F});

    // R10: back-to-back words both applied (4->1 then 5->2)
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = 16'h0802;
    @(negedge clk);
    check("R10", "cmd_ready busy", {63'h0, cmd_ready}, 64'h1);
    cmd_word = 16'h0A04;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10", "out_sel b2b", out_sel, 64'hF000_0000_0000_9542);

    // R3: rewriting group 0 clears its bits, leaves group 3
    send(16'h2004);
    check("R3", "out_enable group", {48'h0, out_enable}, {48'h0, 16'h5002});

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1", 64'h0, 16'h0, 16'h0, 1'b0);
    rst_n = 1'b1;
    send(16'h2055);                                      // R8 power still off
    check("R8", "out_enable no power", {48'h0, out_enable}, 64'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule